// File: doc/BRIEF.md
# Backup-Domain Clock Control Register

This block is a single 32-bit memory-mapped control register kept in an always-on backup power domain. It holds four control fields: an enable and a bypass for the low-speed external oscillator, a 2-bit clock-source select for the real-time clock, and a clock enable for it. It also holds a software domain-reset bit and shows a read-only oscillator-ready status. The control fields drive the real-time-clock clock mux select, the clock enable, and the oscillator controls directly.

The fields keep their values through system reset. Only the backup-domain reset input or the software domain-reset bit clears them. The four protected fields change only while the power controller holds its write-permission input high. The clock-source select can be written to a nonzero value only once. A hidden lock flag then blocks further changes to it until the domain is reset.

Bus accesses use a request/ready handshake run by a small state machine with four states:
- IDLE: no access.
- ACK: ready is high and a write commits at the end of this cycle.
- HOT: the cycle after an ACK.
- WAIT: extra wait cycles for a back-to-back access.

Transitions:
- IDLE to ACK on a request.
- ACK to HOT always.
- HOT to IDLE when no request is present.
- HOT to WAIT on a request when `WAIT_CYC` is above zero.
- HOT to ACK on a request when `WAIT_CYC` is zero.
- WAIT to ACK when the wait counter reaches zero.

Top module: `bkd_ctrl_reg`

## Requirements
- R1: While `wr_permit` is low, a write leaves `osc_enable`, `osc_bypass`, `rtc_sel` and `rtc_clk_en` unchanged. While it is high, strobed writes update these fields.
- R2: System reset (`sys_rst_n` low) leaves all stored fields unchanged. Backup reset (`bkp_rst_n` low) clears all of them, including the software reset bit and the select lock.
- R3: `rtc_sel` drives the clock-source mux: 00 means no clock, 01 the low-speed external oscillator, 10 the low-speed internal oscillator, 11 the high-speed external clock divided by 128. `rtc_sel`, `rtc_clk_en`, `osc_enable` and `osc_bypass` always equal the stored fields.
- R4: After a committed write of a nonzero value to the select field, later writes to that field are ignored until a domain reset. A committed write of 00 does not lock it.
- R5: Writing 1 to bit 16 clears all four fields and the lock, whatever the level of `wr_permit`. Bit 16 reads back as 1. While it stays 1, writes to the fields are ignored. Writing 0 to it releases the domain.
- R6: Bit 2 is read-only. It reads `osc_rdy_in` as registered one clock earlier, and writes to it have no effect.
- R7: The field positions are: bit 0 oscillator enable, bit 1 bypass, bits 5:4 select, bit 8 clock enable, bit 16 software reset. Byte lane n is written only if `bus_strb[n]` is high, and all other read bits are 0.
- R8: A request sampled in IDLE gets `bus_ready` in the next cycle, with `bus_rdata` holding the register value from before the write.
- R9: A request sampled on the clock edge that ends the cycle after a ready cycle gets `bus_ready` `WAIT_CYC`+1 cycles after that edge. `bus_ready` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low; resets only the handshake |
| bkp_rst_n | input | 1 | Backup-domain reset, active low |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready, else 0 |
| bus_ready | output | 1 | Access completes this cycle |
| wr_permit | input | 1 | Write permission from power controller |
| osc_rdy_in | input | 1 | Oscillator-ready indication |
| osc_enable | output | 1 | Low-speed external oscillator enable |
| osc_bypass | output | 1 | Low-speed external oscillator bypass |
| rtc_sel | output | 2 | Real-time-clock source select |
| rtc_clk_en | output | 1 | Real-time-clock clock enable |

## Verification
The bench first attempts a second nonzero select write after a lock. A design without the lock would switch the clock mux. It then writes 00 first and a nonzero value next; a design that locks on any write would refuse the second value. It also issues writes while the software reset bit is held, and writes that set that bit while permission is low. A wrong design would either let fields through during the hold or ignore the unprotected reset bit. Isolated and back-to-back accesses are measured for latency, and a system-reset pulse is applied to confirm that no field is cleared by it.

// File: rtl/bkd_pkg.sv
package bkd_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_ACK,
        HS_HOT,
        HS_WAIT
    } hs_state_t;

    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    localparam int POS_EN     = 0;
    localparam int POS_BYP    = 1;
    localparam int POS_RDY    = 2;
    localparam int POS_SEL_LO = 4;
    localparam int SEL_W      = 2;
    localparam int POS_CE     = 8;
    localparam int POS_SW     = 16;

    localparam int LANE_EN  = POS_EN / 8;
    localparam int LANE_SEL = POS_SEL_LO / 8;
    localparam int LANE_CE  = POS_CE / 8;
    localparam int LANE_SW  = POS_SW / 8;

endpackage

// File: rtl/bkd_handshake.sv
module bkd_handshake
    import bkd_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic bus_req,
    input  logic bus_we,
    output logic ready,
    output logic commit
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = (WAIT_CYC > 0) ? CNT_W'(WAIT_CYC - 1) : '0;

    hs_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HS_IDLE: begin
                if (bus_req) state_d = HS_ACK;
            end
            HS_ACK: begin
                state_d = HS_HOT;
            end
            HS_HOT: begin
                if (!bus_req) begin
                    state_d = HS_IDLE;
                end else if (WAIT_CYC == 0) begin
                    state_d = HS_ACK;
                end else begin
                    state_d = HS_WAIT;
                    cnt_d   = CNT_LOAD;
                end
            end
            HS_WAIT: begin
                if (cnt_q == '0) state_d = HS_ACK;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ready  = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            HS_ACK: begin
                ready  = 1'b1;
                commit = bus_we;
            end
            HS_IDLE, HS_HOT, HS_WAIT: begin
                ready  = 1'b0;
                commit = 1'b0;
            end
            default: begin
                ready  = 1'b0;
                commit = 1'b0;
            end
        endcase
    end

    p_idle_ack_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (state_q == HS_IDLE && bus_req) |=> ready);

    p_no_double_ready_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ready |=> !ready);

    generate
        if (WAIT_CYC > 0) begin : g_wait_chk
            p_hot_delay_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
                (state_q == HS_HOT && bus_req) |=> !ready);
        end
    endgenerate

endmodule

// File: rtl/bkd_fields.sv
module bkd_fields
    import bkd_pkg::*;
(
    input  logic             clk,
    input  logic             bkp_rst_n,
    input  logic             wr_commit,
    input  logic             wr_permit,
    input  logic [STRB_W-1:0] strb,
    input  logic             wd_en,
    input  logic             wd_byp,
    input  logic [SEL_W-1:0] wd_sel,
    input  logic             wd_ce,
    input  logic             wd_sw,
    input  logic             osc_rdy_in,
    output logic             f_en,
    output logic             f_byp,
    output logic [SEL_W-1:0] f_sel,
    output logic             f_ce,
    output logic             f_sw,
    output logic             f_rdy
);

    logic lock_q;
    logic sw_set;
    logic dom_clear;

    assign sw_set    = wr_commit && strb[LANE_SW] && wd_sw;
    assign dom_clear = f_sw || sw_set;

    always_ff @(posedge clk or negedge bkp_rst_n) begin
        if (!bkp_rst_n) begin
            f_en   <= 1'b0;
            f_byp  <= 1'b0;
            f_sel  <= '0;
            f_ce   <= 1'b0;
            f_sw   <= 1'b0;
            f_rdy  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            f_rdy <= osc_rdy_in;
            if (wr_commit && strb[LANE_SW]) f_sw <= wd_sw;
            if (dom_clear) begin
                f_en   <= 1'b0;
                f_byp  <= 1'b0;
                f_sel  <= '0;
                f_ce   <= 1'b0;
                lock_q <= 1'b0;
            end else if (wr_commit && wr_permit) begin
                if (strb[LANE_EN]) begin
                    f_en  <= wd_en;
                    f_byp <= wd_byp;
                end
                if (strb[LANE_SEL] && !lock_q) begin
                    f_sel  <= wd_sel;
                    lock_q <= |wd_sel;
                end
                if (strb[LANE_CE]) f_ce <= wd_ce;
            end
        end
    end

    p_perm_gate_r1: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (!wr_permit && !dom_clear) |=> $stable({f_en, f_byp, f_sel, f_ce}));

    p_lock_r4: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (lock_q && !dom_clear) |=> (f_sel == $past(f_sel)));

    p_lock_nonzero_r4: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        lock_q |-> (f_sel != '0));

    p_swrst_hold_r5: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        f_sw |-> ({f_en, f_byp, f_sel, f_ce} == '0 && !lock_q));

    p_rdy_follow_r6: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        1'b1 |=> (f_rdy == $past(osc_rdy_in)));

endmodule

// File: rtl/bkd_readback.sv
module bkd_readback
    import bkd_pkg::*;
(
    input  logic             f_en,
    input  logic             f_byp,
    input  logic [SEL_W-1:0] f_sel,
    input  logic             f_ce,
    input  logic             f_sw,
    input  logic             f_rdy,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word = '0;
        word[POS_EN]                         = f_en;
        word[POS_BYP]                        = f_byp;
        word[POS_RDY]                        = f_rdy;
        word[POS_SEL_LO +: SEL_W]            = f_sel;
        word[POS_CE]                         = f_ce;
        word[POS_SW]                         = f_sw;
    end

endmodule

// File: rtl/bkd_ctrl_reg.sv
module bkd_ctrl_reg
    import bkd_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic        clk,
    input  logic        sys_rst_n,
    input  logic        bkp_rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [3:0]  bus_strb,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    input  logic        wr_permit,
    input  logic        osc_rdy_in,
    output logic        osc_enable,
    output logic        osc_bypass,
    output logic [1:0]  rtc_sel,
    output logic        rtc_clk_en
);

    logic             hs_ready;
    logic             hs_commit;
    logic             f_ce;
    logic             f_sw;
    logic             f_rdy;
    logic [DATA_W-1:0] rd_word;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[31:17], bus_wdata[15:9], bus_wdata[7:6],
                           bus_wdata[3:2], bus_strb[3]};

    bkd_handshake #(.WAIT_CYC(WAIT_CYC)) i_hs (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .ready     (hs_ready),
        .commit    (hs_commit)
    );

    bkd_fields i_fields (
        .clk        (clk),
        .bkp_rst_n  (bkp_rst_n),
        .wr_commit  (hs_commit),
        .wr_permit  (wr_permit),
        .strb       (bus_strb),
        .wd_en      (bus_wdata[POS_EN]),
        .wd_byp     (bus_wdata[POS_BYP]),
        .wd_sel     (bus_wdata[POS_SEL_LO +: SEL_W]),
        .wd_ce      (bus_wdata[POS_CE]),
        .wd_sw      (bus_wdata[POS_SW]),
        .osc_rdy_in (osc_rdy_in),
        .f_en       (osc_enable),
        .f_byp      (osc_bypass),
        .f_sel      (rtc_sel),
        .f_ce       (f_ce),
        .f_sw       (f_sw),
        .f_rdy      (f_rdy)
    );

    bkd_readback i_rb (
        .f_en  (osc_enable),
        .f_byp (osc_bypass),
        .f_sel (rtc_sel),
        .f_ce  (f_ce),
        .f_sw  (f_sw),
        .f_rdy (f_rdy),
        .word  (rd_word)
    );

    assign rtc_clk_en = f_ce;
    assign bus_ready  = hs_ready;
    assign bus_rdata  = hs_ready ? rd_word : '0;

    p_sysrst_keep_r2: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        !sys_rst_n |=> $stable({rtc_sel, rtc_clk_en, osc_enable, osc_bypass, f_sw}));

endmodule

// File: tb/test_bkd_ctrl_reg.sv
module test_bkd_ctrl_reg;

    localparam int W = 2;

    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bkp_rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        wr_permit = 1'b0;
    logic        osc_rdy_in = 1'b0;
    logic        osc_enable, osc_bypass, rtc_clk_en;
    logic [1:0]  rtc_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    bit       m_en, m_byp, m_ce, m_sw, m_lock, m_rdy;
    bit [1:0] m_sel;

    always #5 clk = ~clk;

    bkd_ctrl_reg #(.WAIT_CYC(W)) i_bkd_ctrl_reg (
        .clk(clk), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_strb(bus_strb),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .wr_permit(wr_permit), .osc_rdy_in(osc_rdy_in),
        .osc_enable(osc_enable), .osc_bypass(osc_bypass),
        .rtc_sel(rtc_sel), .rtc_clk_en(rtc_clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[0] = m_en; w[1] = m_byp; w[2] = m_rdy;
        w[5:4] = m_sel; w[8] = m_ce; w[16] = m_sw;
        return w;
    endfunction

    function automatic void model_clear();
        m_en = 0; m_byp = 0; m_sel = 0; m_ce = 0; m_sw = 0; m_lock = 0;
    endfunction

    function automatic void model_write(input logic [3:0] s, input logic [31:0] d, input bit p);
        bit new_sw = s[2] ? d[16] : m_sw;
        if (m_sw || (s[2] && d[16])) begin
            m_en = 0; m_byp = 0; m_sel = 0; m_ce = 0; m_lock = 0;
        end else if (p) begin
            if (s[0]) begin
                m_en = d[0]; m_byp = d[1];
                if (!m_lock) begin m_sel = d[5:4]; m_lock = (d[5:4] != 0); end
            end
            if (s[1]) m_ce = d[8];
        end
        m_sw = new_sw;
    endfunction

    task automatic check_ports(input string tag);
        chk({tag, " R3 ports"}, {27'd0, rtc_sel, rtc_clk_en, osc_enable, osc_bypass},
            {27'd0, m_sel, m_ce, m_en, m_byp});
    endtask

    // one access; bench stands just after a posedge on entry and on exit
    task automatic access(input bit b2b, input bit we, input logic [3:0] s,
                          input logic [31:0] d, input bit p, input bit rdy, input string tag);
        int lat = 0;
        logic [31:0] exp;
        if (!b2b) begin
            bus_req = 0;
            @(negedge clk); check_ports(tag);
            @(posedge clk); #1;
            osc_rdy_in = rdy;
            m_rdy = rdy;
        end
        bus_req = 1; bus_we = we; bus_strb = s; bus_wdata = d; wr_permit = p;
        do begin
            @(negedge clk); lat++;
            if (b2b && lat == 1) check_ports(tag);
        end while (!bus_ready && lat < 20);
        exp = exp_word();
        chk({tag, " R7 rdata"}, bus_rdata, exp);
        chk(b2b ? {tag, " R9 latency"} : {tag, " R8 latency"}, lat, b2b ? W + 2 : 2);
        if (we) model_write(s, d, p);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear(); m_rdy = 0;
        repeat (3) @(posedge clk);
        #1; sys_rst_n = 1; bkp_rst_n = 1;
        @(negedge clk);
        chk("R2 reset ready", {31'd0, bus_ready}, 0);
        check_ports("R2 reset");
        @(posedge clk); #1;

        // R1: no permission -> ignored
        access(0, 1, 4'b0011, 32'h0000_0113, 0, 0, "R1 noperm");
        access(0, 0, 4'b0000, 0, 0, 0, "R1 readback");
        // R1/R3: permitted write, select 01 locks (R4)
        access(0, 1, 4'b0011, 32'h0000_0111, 1, 1, "R1 perm");
        access(0, 1, 4'b0001, 32'h0000_0020, 1, 1, "R4 locked");
        access(0, 0, 4'b0000, 0, 0, 1, "R4 readback");
        // R7: lane 1 only touches clock enable
        access(0, 1, 4'b0010, 32'h0000_0033, 1, 0, "R7 lane1");
        // R6: write to status bit has no effect
        access(0, 1, 4'b0001, 32'h0000_0004, 1, 0, "R6 ro");
        // R5: set domain reset without permission
        access(0, 1, 4'b0100, 32'h0001_0000, 0, 1, "R5 set");
        access(0, 1, 4'b0011, 32'h0000_0133, 1, 1, "R5 held");
        access(0, 1, 4'b0100, 32'h0000_0000, 1, 1, "R5 release");
        // R4: select 00 does not lock; then 11 accepted
        access(0, 1, 4'b0001, 32'h0000_0000, 1, 0, "R4 zero");
        access(0, 1, 4'b0001, 32'h0000_0030, 1, 0, "R4 three");
        access(0, 1, 4'b0001, 32'h0000_0010, 1, 0, "R4 relock");
        // R9: back-to-back
        access(1, 0, 4'b0000, 0, 0, 0, "R9 b2b");
        access(1, 1, 4'b0010, 32'h0000_0100, 1, 0, "R9 b2b wr");

        // R2: system reset keeps fields
        bus_req = 0; sys_rst_n = 0;
        repeat (3) @(negedge clk);
        check_ports("R2 sysrst");
        @(posedge clk); #1; sys_rst_n = 1;
        access(0, 0, 4'b0000, 0, 0, 0, "R2 after sysrst");

        // random phase
        for (int i = 0; i < 80; i++) begin
            bit b2b = ($urandom % 2) == 1;
            bit we  = ($urandom % 4) != 0;
            logic [3:0] s = 4'($urandom);
            logic [31:0] d = $urandom & 32'hFFFE_FFFF;
            bit p = ($urandom % 3) != 0;
            bit r = b2b ? osc_rdy_in : bit'($urandom % 2);
            if (($urandom % 8) == 0) d[16] = 1'b1;
            access(b2b, we, s, d, p, r, "rand");
        end

        // R2: backup reset clears all
        bus_req = 0; bkp_rst_n = 0; osc_rdy_in = 0;
        model_clear(); m_rdy = 0;
        @(negedge clk);
        check_ports("R2 bkprst");
        @(posedge clk); #1; bkp_rst_n = 1;
        access(0, 0, 4'b0000, 0, 0, 0, "R2 after bkprst");
        access(0, 1, 4'b0001, 32'h0000_0020, 1, 0, "R4 after bkprst");
        access(0, 0, 4'b0000, 0, 0, 0, "final");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule